// File: doc/BRIEF.md
# Routed Interrupt Aggregation Controller

This block gathers a bank of level-sensitive peripheral interrupt requests and steers each one onto one of a small set of CPU-facing request lines. Each request is first brought into the controller's clock domain. Software then chooses, per request, whether it may reach the CPU at all (a global enable word) and which CPU line it should drive (a 4-bit routing code per request).

Each CPU line is a registered OR of every enabled, active request whose routing code names that line. Code 0 leaves a request unconnected. Codes above the number of built lines drive nothing.

Software reaches the enable word, a read-only snapshot of the synchronized request levels, and the routing words over a plain 32-bit register bus with single-cycle write strobes and registered read data. The routing words are packed in reverse address order: the highest routing address carries the lowest-numbered requests. Drivers therefore compute the location of a request's field from its number.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset, every output line is low, and the enable word and all four routing words read back as zero.
- R2: A write to offset 0x00 replaces the enable word (bit n enables request n), and a read of 0x00 returns the last value written.
- R3: Offset 0x04 returns the request levels after a two-flop synchronizer. A level driven on the input is visible to a read issued two clock edges later and not to one issued one edge later. Writes to 0x04 have no effect.
- R4: The routing words at offsets 0x08, 0x0C, 0x10 and 0x14 hold full 32-bit values written by software, and read back unchanged.
- R5: The routing code of request n sits in bits [4*(n mod 8)+3 : 4*(n mod 8)] of the word at offset 0x14 − 4*(n div 8). Requests 0–7 are at 0x14 and requests 24–31 are at 0x08.
- R6: A request whose routing code is 0 drives no output line.
- R7: A request with code k in 1..6 drives output line k−1. An output goes high three clock edges after the input level changes: two synchronizer stages plus the output register.
- R8: Routing codes 7 through 15 drive no output line.
- R9: A request whose enable bit is 0 drives no output line, whatever its level and routing code.
- R10: Several requests routed to the same line combine by OR. The line stays high until the last of them falls.
- R11: Read data appears on the edge after the read strobe. A read of an unmapped offset returns zero, whether the offset is past 0x14 or has nonzero low two bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | 32 | Level-sensitive peripheral requests, asynchronous |
| bus_wr_en | input | 1 | Register write strobe |
| bus_rd_en | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_out | output | 6 | CPU-facing request lines |

## Verification
The bench builds the controller with its default values: 32 requests, 4-bit routing fields, six output lines and an 8-bit offset. These values make every routing word and both ends of the reversed packing reachable, at requests 0, 7, 8, 23 and 31. The codes just past the last built line (7) and the top code (15) are also in reach. With six lines, the bench can drive every line and compare the outputs against a model of enable, level and routing code. It also checks the exact three-edge latency and the moment a status read first sees a new level.

// File: rtl/irq_route_pkg.sv
`timescale 1ns/1ps
package irq_route_pkg;
  localparam int WORD_BITS  = 32;
  localparam int WORD_BYTES = WORD_BITS / 8;
  // Word indices on the register bus (byte offset / 4)
  localparam int IDX_ENABLE = 0;
  localparam int IDX_LEVEL  = 1;
  localparam int IDX_ROUTE0 = 2;
endpackage

// File: rtl/irq_sync.sv
`timescale 1ns/1ps
module irq_sync #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
    end else begin
      stage_q[0] <= async_in;
      for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/irq_regs.sv
`timescale 1ns/1ps
module irq_regs
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC  = 32,
  parameter int ADDR_W   = 8,
  parameter int NUM_RREG = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_en,
  input  logic                          rd_en,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [WORD_BITS-1:0]          wdata,
  input  logic [NUM_SRC-1:0]            level,
  output logic [NUM_SRC-1:0]            enable_q,
  output logic [NUM_RREG*WORD_BITS-1:0] route_q,
  output logic [WORD_BITS-1:0]          rdata
);
  localparam int IDX_W = ADDR_W - 2;

  logic             aligned;
  logic [IDX_W-1:0] widx;
  logic [WORD_BITS-1:0] rd_mux;

  assign aligned = (addr[1:0] == 2'b00);
  assign widx    = addr[ADDR_W-1:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= '0;
      route_q  <= '0;
    end else if (wr_en && aligned) begin
      if (widx == IDX_W'(IDX_ENABLE)) enable_q <= wdata[NUM_SRC-1:0];
      for (int r = 0; r < NUM_RREG; r++) begin
        if (widx == IDX_W'(IDX_ROUTE0 + r)) route_q[r*WORD_BITS +: WORD_BITS] <= wdata;
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    if (aligned) begin
      if (widx == IDX_W'(IDX_ENABLE)) rd_mux = WORD_BITS'(enable_q);
      if (widx == IDX_W'(IDX_LEVEL))  rd_mux = WORD_BITS'(level);
      for (int r = 0; r < NUM_RREG; r++) begin
        if (widx == IDX_W'(IDX_ROUTE0 + r)) rd_mux = route_q[r*WORD_BITS +: WORD_BITS];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_line_map.sv
`timescale 1ns/1ps
module irq_line_map
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC   = 32,
  parameter int NUM_LINES = 6,
  parameter int FIELD_W   = 4,
  parameter int NUM_RREG  = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic [NUM_SRC-1:0]            enable,
  input  logic [NUM_SRC-1:0]            level,
  input  logic [NUM_RREG*WORD_BITS-1:0] route,
  output logic [NUM_LINES-1:0]          lines_q
);
  localparam int PER_REG = WORD_BITS / FIELD_W;

  logic [NUM_SRC-1:0] live;
  logic [FIELD_W-1:0] code [NUM_SRC];
  logic [NUM_LINES-1:0] hit;

  assign live = enable & level;

  // Reverse packing: the last routing word holds the lowest requests
  for (genvar n = 0; n < NUM_SRC; n++) begin : g_field
    localparam int REG_I = NUM_RREG - 1 - (n / PER_REG);
    localparam int BIT_I = REG_I * WORD_BITS + (n % PER_REG) * FIELD_W;
    assign code[n] = route[BIT_I +: FIELD_W];
  end

  for (genvar j = 0; j < NUM_LINES; j++) begin : g_line
    localparam logic [FIELD_W-1:0] SEL = FIELD_W'(j + 1);
    logic [NUM_SRC-1:0] match;
    for (genvar n = 0; n < NUM_SRC; n++) begin : g_match
      assign match[n] = live[n] && (code[n] == SEL);
    end
    assign hit[j] = |match;
  end

  always_ff @(posedge clk) begin
    if (rst) lines_q <= '0;
    else     lines_q <= hit;
  end
endmodule

// File: rtl/irq_route_ctrl.sv
`timescale 1ns/1ps
module irq_route_ctrl
  import irq_route_pkg::*;
#(
  parameter int NUM_SRC     = 32,
  parameter int NUM_LINES   = 6,
  parameter int FIELD_W     = 4,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NUM_SRC-1:0]   irq_in,
  input  logic                 bus_wr_en,
  input  logic                 bus_rd_en,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [WORD_BITS-1:0] bus_wdata,
  output logic [WORD_BITS-1:0] bus_rdata,
  output logic [NUM_LINES-1:0] irq_out
);
  localparam int NUM_RREG = (NUM_SRC * FIELD_W) / WORD_BITS;

  logic [NUM_SRC-1:0]            status_q;
  logic [NUM_SRC-1:0]            mask_q;
  logic [NUM_RREG*WORD_BITS-1:0] route_q;

  irq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .async_in(irq_in), .sync_out(status_q)
  );

  irq_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W), .NUM_RREG(NUM_RREG)) regs_i (
    .clk(clk), .rst(rst), .wr_en(bus_wr_en), .rd_en(bus_rd_en),
    .addr(bus_addr), .wdata(bus_wdata), .level(status_q),
    .enable_q(mask_q), .route_q(route_q), .rdata(bus_rdata)
  );

  irq_line_map #(.NUM_SRC(NUM_SRC), .NUM_LINES(NUM_LINES), .FIELD_W(FIELD_W),
                 .NUM_RREG(NUM_RREG)) map_i (
    .clk(clk), .rst(rst), .enable(mask_q), .level(status_q),
    .route(route_q), .lines_q(irq_out)
  );
endmodule

// File: rtl/irq_route_ctrl_chk.sv
`timescale 1ns/1ps
module irq_route_ctrl_chk #(
  parameter int NUM_SRC   = 32,
  parameter int NUM_LINES = 6,
  parameter int ADDR_W    = 8,
  parameter int RBITS     = 128
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_SRC-1:0]   irq_in,
  input logic                 bus_wr_en,
  input logic                 bus_rd_en,
  input logic [ADDR_W-1:0]    bus_addr,
  input logic [31:0]          bus_wdata,
  input logic [31:0]          bus_rdata,
  input logic [NUM_LINES-1:0] irq_out,
  input logic [NUM_SRC-1:0]   mask_q,
  input logic [NUM_SRC-1:0]   status_q,
  input logic [RBITS-1:0]     route_q
);
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                   since_rst <= '0;
    else if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
  end

  // R2
  enable_write_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr_en && bus_addr == '0) |=> (mask_q == $past(bus_wdata[NUM_SRC-1:0])));

  // R3
  level_sync_chk: assert property (@(posedge clk) disable iff (rst)
    (since_rst == 2'd2) |-> (status_q == $past(irq_in, 2)));

  // R6
  all_open_chk: assert property (@(posedge clk) disable iff (rst)
    (route_q == '0) |=> (irq_out == '0));

  // R9
  all_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> (irq_out == '0));

  // R11
  misaligned_read_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd_en && bus_addr[1:0] != 2'b00) |=> (bus_rdata == '0));
endmodule

bind irq_route_ctrl irq_route_ctrl_chk #(
  .NUM_SRC(NUM_SRC), .NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W), .RBITS(NUM_RREG*32)
) chk_i (
  .clk(clk), .rst(rst), .irq_in(irq_in), .bus_wr_en(bus_wr_en),
  .bus_rd_en(bus_rd_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .irq_out(irq_out), .mask_q(mask_q),
  .status_q(status_q), .route_q(route_q)
);

// File: tb/irq_route_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_route_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irq_in = '0;
  logic        bus_wr_en = 1'b0;
  logic        bus_rd_en = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [5:0]  irq_out;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [31:0] sh_mask;
  logic [31:0] sh_route [4];
  logic [31:0] sh_in;

  irq_route_ctrl dut_i (
    .clk(clk), .rst(rst), .irq_in(irq_in), .bus_wr_en(bus_wr_en),
    .bus_rd_en(bus_rd_en), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  always #2.5 clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_wr_en = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr_en = 1'b0;
  endtask

  task automatic bus_read(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd_en = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata;
  endtask

  task automatic wr_mask(logic [31:0] v);
    sh_mask = v;
    bus_write(8'h00, v);
  endtask

  // R5 placement: word at 0x14 - 4*(n/8), nibble n%8
  task automatic route_src(int n, logic [3:0] code);
    int r;
    r = 3 - n / 8;
    sh_route[r][4*(n%8) +: 4] = code;
    bus_write(8'h08 + 8'(4*r), sh_route[r]);
  endtask

  task automatic set_in(logic [31:0] v);
    @(negedge clk);
    irq_in = v; sh_in = v;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [5:0] model();
    logic [5:0] m;
    logic [3:0] c;
    m = '0;
    for (int n = 0; n < 32; n++) begin
      c = sh_route[3 - n/8][4*(n%8) +: 4];
      if (sh_mask[n] && sh_in[n] && c >= 4'd1 && c <= 4'd6) m[c-1] = 1'b1;
    end
    return m;
  endfunction

  task automatic clear_all();
    wr_mask('0);
    for (int r = 0; r < 4; r++) begin
      sh_route[r] = '0;
      bus_write(8'h08 + 8'(4*r), '0);
    end
    set_in('0);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 out", 32'(irq_out), '0);
    bus_read(8'h00, d); chk("R1 mask", d, '0);
    for (int r = 0; r < 4; r++) begin
      bus_read(8'h08 + 8'(4*r), d); chk("R1 route", d, '0);
    end
  endtask

  task automatic t_mask_rw();
    logic [31:0] d;
    wr_mask(32'hA5A5_F00F); bus_read(8'h00, d); chk("R2 mask", d, 32'hA5A5_F00F);
    wr_mask(32'h0000_0001); bus_read(8'h00, d); chk("R2 mask2", d, 32'h1);
    wr_mask('0);
  endtask

  task automatic t_status();
    logic [31:0] d;
    @(negedge clk); irq_in = 32'h8000_0001; sh_in = irq_in;
    bus_read(8'h04, d); chk("R3 early", d, '0);
    bus_read(8'h04, d); chk("R3 level", d, 32'h8000_0001);
    bus_write(8'h04, 32'hFFFF_FFFF);
    bus_read(8'h04, d); chk("R3 ro", d, 32'h8000_0001);
    set_in('0);
    bus_read(8'h04, d); chk("R3 clear", d, '0);
  endtask

  task automatic t_route_rw();
    logic [31:0] d;
    for (int r = 0; r < 4; r++) begin
      sh_route[r] = 32'h1357_9BDF ^ (32'h1111_1111 * r);
      bus_write(8'h08 + 8'(4*r), sh_route[r]);
    end
    for (int r = 0; r < 4; r++) begin
      bus_read(8'h08 + 8'(4*r), d); chk("R4 route", d, sh_route[r]);
    end
    clear_all();
  endtask

  task automatic t_packing();
    int srcs [5] = '{0, 7, 8, 23, 31};
    bus_write(8'h14, 32'h0000_0001); sh_route[0] = 32'h1;
    wr_mask(32'h1);
    set_in(32'h1);
    chk("R5 raw 0x14", 32'(irq_out), 32'h01);
    clear_all();
    foreach (srcs[i]) begin
      wr_mask(32'h1 << srcs[i]);
      route_src(srcs[i], 4'(1 + i));
      set_in(32'h1 << srcs[i]);
      chk("R5 R7 packing", 32'(irq_out), 32'(model()));
      chk("R7 line", 32'(irq_out), 32'h1 << i);
      clear_all();
    end
  endtask

  task automatic t_latency();
    wr_mask(32'h0000_0400);
    route_src(10, 4'd6);
    @(negedge clk); irq_in = 32'h400; sh_in = irq_in;
    repeat (2) @(negedge clk);
    chk("R7 not yet", 32'(irq_out), '0);
    @(negedge clk);
    chk("R7 line5", 32'(irq_out), 32'h20);
    clear_all();
  endtask

  task automatic t_codes();
    wr_mask(32'hFFFF_FFFF);
    route_src(3, 4'd0);
    set_in(32'h8);
    chk("R6 open", 32'(irq_out), '0);
    route_src(3, 4'd7);
    route_src(4, 4'd15);
    set_in(32'h18);
    chk("R8 high codes", 32'(irq_out), '0);
    clear_all();
  endtask

  task automatic t_mask_gate();
    route_src(20, 4'd3);
    set_in(32'h0010_0000);
    chk("R9 masked", 32'(irq_out), '0);
    wr_mask(32'h0010_0000);
    @(negedge clk);
    chk("R9 unmasked", 32'(irq_out), 32'h04);
    clear_all();
  endtask

  task automatic t_or();
    wr_mask(32'hFFFF_FFFF);
    route_src(5, 4'd2);
    route_src(27, 4'd2);
    route_src(12, 4'd4);
    set_in(32'h0800_1020);
    chk("R10 both", 32'(irq_out), 32'(model()));
    set_in(32'h0800_0000);
    chk("R10 one", 32'(irq_out), 32'h02);
    set_in('0);
    chk("R10 none", 32'(irq_out), '0);
    clear_all();
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr_mask(32'hFFFF_FFFF);
    bus_read(8'h18, d); chk("R11 past end", d, '0);
    bus_read(8'h01, d); chk("R11 misaligned", d, '0);
    bus_read(8'h00, d); chk("R11 mapped", d, 32'hFFFF_FFFF);
    clear_all();
  endtask

  initial begin
    sh_mask = '0; sh_in = '0;
    for (int r = 0; r < 4; r++) sh_route[r] = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_mask_rw();
    t_status();
    t_route_rw();
    t_packing();
    t_latency();
    t_codes();
    t_mask_gate();
    t_or();
    t_unmapped();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule